// File: doc/BRIEF.md
# SCSI Bus Arbitration Unit

This block runs the arbitration step of a SCSI controller. Software raises a level-sensitive request and supplies the device's own ID as a single set bit on an 8-bit vector. The unit then watches the sampled BSY and SEL lines until the bus has been free for a set number of clock cycles. Only then does it compete: it drives BSY and its own ID bit onto the data lines. After a further arbitration delay it reads back the data lines and decides whether it has won.

Two status flags report the result to the CPU: an in-progress flag and a lost flag. The unit holds the bus after a win until software withdraws the request. A loss is sticky until the request is withdrawn. Withdrawing the request at any time returns the unit to idle and releases every line it drives.

All pins are plain level control and status; there is no streaming data path, so no valid/ready handshake applies. Bus-free length and arbitration delay are cycle-count parameters.

Top module: `scsi_arb_unit`

## Requirements
- R1: After reset, `drv_bsy_o`, `drv_data_o`, `in_prog_o` and `lost_o` are all 0.
- R2: With `arb_req_i` high and a valid ID, the unit first drives BSY exactly FREE_CYC+1 clock edges after the edge that samples the request, provided BSY and SEL are low throughout.
- R3: Any cycle with `bus_bsy_i` or `bus_sel_i` high while waiting restarts the bus-free count. Driving then begins FREE_CYC edges after the first edge that sees the bus idle again.
- R4: While competing, the unit drives `drv_bsy_o`=1 and `drv_data_o` equal to its ID, and holds `in_prog_o`=1.
- R5: ARB_DLY edges after driving begins, the unit compares `bus_data_i` with its ID, where bit 7 has the highest priority and bit 0 the lowest. If any bit above its own is set, it sets `lost_o`, clears `in_prog_o` and releases BSY and data.
- R6: If no higher bit is set at that comparison, the unit keeps driving BSY and its ID and keeps `in_prog_o`=1 while the request stays high.
- R7: `bus_sel_i` high on an edge while competing makes the unit lose from the next cycle on: `lost_o`=1 and all lines released.
- R8: `arb_req_i` low on any edge makes all four outputs 0 after that edge.
- R9: If the ID is zero or has more than one bit set when the request is first sampled, the unit sets `lost_o` on the next cycle and never drives the bus.
- R10: After a loss, `lost_o` stays 1 and the bus stays released for as long as the request stays high, even when the bus becomes free.
- R11: The ID is captured when the request is first sampled. Later changes to `own_id_i` do not change `drv_data_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arb_req_i | input | 1 | Arbitration request level from software |
| own_id_i | input | 8 | Device ID, one-hot |
| bus_data_i | input | 8 | Sampled SCSI data lines, active high |
| bus_bsy_i | input | 1 | Sampled BSY line, active high |
| bus_sel_i | input | 1 | Sampled SEL line, active high |
| drv_bsy_o | output | 1 | Drive BSY onto the bus |
| drv_data_o | output | 8 | Data bits to drive, the own ID while competing |
| in_prog_o | output | 1 | Arbitration in progress or won |
| lost_o | output | 1 | Arbitration lost (sticky) |

## Verification
The hardest situation to reach from the ports is a bus-free count that is cut short partway through the wait. Catching the reset of that count needs a BSY or SEL pulse landing on an exact cycle inside the window. The bench places such a pulse a fixed number of edges after the request, then counts the edges to the first drive of BSY. It also sweeps every own-ID bit against every single competing bit and against no competitor, and asserts SEL at a chosen point inside the arbitration delay.

// File: rtl/scsi_arb_pkg.sv
package scsi_arb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_ARB,
    ST_WON,
    ST_LOST
  } arb_state_e;
endpackage

// File: rtl/scsi_arb_free_det.sv
module scsi_arb_free_det #(
  parameter int FREE_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic bsy_i,
  input  logic sel_i,
  output logic free_o
);
  localparam int CNT_W = $clog2(FREE_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FREE_CYC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             idle;

  assign idle   = !bsy_i && !sel_i;
  assign free_o = en_i && idle && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!en_i || !idle || free_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R3: a busy bus always clears the running count
  p_busy_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !idle) |=> (cnt_q == '0));
endmodule

// File: rtl/scsi_arb_timer.sv
module scsi_arb_timer #(
  parameter int ARB_DLY = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic done_o
);
  localparam int CNT_W = $clog2(ARB_DLY + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ARB_DLY - 1);

  logic [CNT_W-1:0] cnt_q;

  assign done_o = en_i && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!en_i || done_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/scsi_arb_prio.sv
module scsi_arb_prio #(
  parameter int ID_W = 8
) (
  input  logic [ID_W-1:0] id_i,
  input  logic [ID_W-1:0] cand_i,
  input  logic [ID_W-1:0] bus_i,
  output logic            higher_o,
  output logic            cand_ok_o
);
  logic [ID_W-1:0] above;

  assign above[0] = 1'b0;
  for (genvar i = 1; i < ID_W; i++) begin : g_above
    assign above[i] = above[i-1] | id_i[i-1];
  end

  assign higher_o  = |(bus_i & above);
  assign cand_ok_o = (|cand_i) && !(|(cand_i & (cand_i - 1'b1)));
endmodule

// File: rtl/scsi_arb_unit.sv
module scsi_arb_unit
  import scsi_arb_pkg::*;
#(
  parameter int ID_W     = 8,
  parameter int FREE_CYC = 4,
  parameter int ARB_DLY  = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            arb_req_i,
  input  logic [ID_W-1:0] own_id_i,
  input  logic [ID_W-1:0] bus_data_i,
  input  logic            bus_bsy_i,
  input  logic            bus_sel_i,
  output logic            drv_bsy_o,
  output logic [ID_W-1:0] drv_data_o,
  output logic            in_prog_o,
  output logic            lost_o
);
  arb_state_e      state_q;
  logic [ID_W-1:0] id_q;
  logic            bus_free, dly_done, higher_seen, cand_ok, driving;

  scsi_arb_free_det #(.FREE_CYC(FREE_CYC)) u_free (
    .clk(clk), .rst_n(rst_n), .en_i(state_q == ST_WAIT),
    .bsy_i(bus_bsy_i), .sel_i(bus_sel_i), .free_o(bus_free)
  );

  scsi_arb_timer #(.ARB_DLY(ARB_DLY)) u_timer (
    .clk(clk), .rst_n(rst_n), .en_i(state_q == ST_ARB && arb_req_i),
    .done_o(dly_done)
  );

  scsi_arb_prio #(.ID_W(ID_W)) u_prio (
    .id_i(id_q), .cand_i(own_id_i), .bus_i(bus_data_i),
    .higher_o(higher_seen), .cand_ok_o(cand_ok)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      id_q    <= '0;
    end else if (!arb_req_i) begin
      state_q <= ST_IDLE;
      id_q    <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (cand_ok) begin
            state_q <= ST_WAIT;
            id_q    <= own_id_i;
          end else begin
            state_q <= ST_LOST;
          end
        end
        ST_WAIT: if (bus_free) state_q <= ST_ARB;
        ST_ARB: begin
          if (bus_sel_i)     state_q <= ST_LOST;
          else if (dly_done) state_q <= higher_seen ? ST_LOST : ST_WON;
        end
        ST_WON:  state_q <= ST_WON;
        ST_LOST: state_q <= ST_LOST;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign driving    = (state_q == ST_ARB) || (state_q == ST_WON);
  assign drv_bsy_o  = driving;
  assign drv_data_o = driving ? id_q : '0;
  assign in_prog_o  = driving;
  assign lost_o     = (state_q == ST_LOST);

  // R2: driving only starts after an idle bus cycle
  p_free_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_bsy_o) |-> $past(!bus_bsy_i && !bus_sel_i));
  // R4: exactly one ID bit is driven
  p_one_id_r4: assert property (@(posedge clk) disable iff (!rst_n)
    drv_bsy_o |-> ($countones(drv_data_o) == 1));
  // R7: SEL while competing forces a loss
  p_sel_loss_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ARB && arb_req_i && bus_sel_i) |=> (lost_o && !drv_bsy_o));
  // R8: withdrawal releases everything
  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !arb_req_i |=> (!drv_bsy_o && drv_data_o == '0 && !in_prog_o && !lost_o));
  // R10: a loss is sticky
  p_lost_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (lost_o && arb_req_i) |=> (lost_o && !drv_bsy_o));
  // R11: driven ID does not move
  p_id_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_bsy_o && $past(drv_bsy_o)) |-> $stable(drv_data_o));
endmodule

// File: tb/tb_scsi_arb_unit.sv
module tb_scsi_arb_unit;
  localparam int FC = 4;
  localparam int AD = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       arb_req_i = 1'b0;
  logic [7:0] own_id_i = '0;
  logic [7:0] bus_data_i = '0;
  logic       bus_bsy_i = 1'b0;
  logic       bus_sel_i = 1'b0;
  logic       drv_bsy_o, in_prog_o, lost_o;
  logic [7:0] drv_data_o;
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  scsi_arb_unit #(.ID_W(8), .FREE_CYC(FC), .ARB_DLY(AD)) dut (
    .clk(clk), .rst_n(rst_n), .arb_req_i(arb_req_i), .own_id_i(own_id_i),
    .bus_data_i(bus_data_i), .bus_bsy_i(bus_bsy_i), .bus_sel_i(bus_sel_i),
    .drv_bsy_o(drv_bsy_o), .drv_data_o(drv_data_o),
    .in_prog_o(in_prog_o), .lost_o(lost_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // packs outputs as {drv_bsy, in_prog, lost, drv_data}
  function automatic logic [31:0] outs();
    return {21'd0, drv_bsy_o, in_prog_o, lost_o, drv_data_o};
  endfunction

  function automatic logic [31:0] exp_outs(input logic b, input logic p,
                                           input logic l, input logic [7:0] d);
    return {21'd0, b, p, l, d};
  endfunction

  task automatic release_all();
    arb_req_i = 0; bus_data_i = '0; bus_bsy_i = 0; bus_sel_i = 0;
    tick(1);
    chk("R8 release", outs(), exp_outs(0, 0, 0, 8'h00));
  endtask

  initial begin
    tick(2);
    chk("R1 reset outputs", outs(), exp_outs(0, 0, 0, 8'h00));
    rst_n = 1;
    tick(1);
    chk("R1 idle after reset", outs(), exp_outs(0, 0, 0, 8'h00));

    // R5/R6 sweep: every own bit against every single competitor or none
    for (int own = 0; own < 8; own++) begin
      for (int comp = 0; comp < 9; comp++) begin
        logic [7:0] id;
        logic lose;
        id = 8'(1 << own);
        lose = (comp < 8) && (comp > own);
        own_id_i = id; arb_req_i = 1;
        tick(FC);
        chk("R2 no drive before free window", {31'd0, drv_bsy_o}, 0);
        tick(1);
        chk("R4 competing outputs", outs(), exp_outs(1, 1, 0, id));
        bus_bsy_i = 1;
        bus_data_i = id | ((comp < 8) ? 8'(1 << comp) : 8'h00);
        tick(AD - 1);
        chk("R4 still competing before delay", outs(), exp_outs(1, 1, 0, id));
        tick(1);
        if (lose) chk("R5 lost to higher id", outs(), exp_outs(0, 0, 1, 8'h00));
        else      chk("R6 won", outs(), exp_outs(1, 1, 0, id));
        tick(3);
        if (lose) chk("R10 loss sticky", outs(), exp_outs(0, 0, 1, 8'h00));
        else      chk("R6 win held", outs(), exp_outs(1, 1, 0, id));
        release_all();
      end
    end

    // R3: busy pulse (BSY then SEL) restarts the bus-free count
    for (int v = 0; v < 2; v++) begin
      own_id_i = 8'h08; arb_req_i = 1;
      tick(3);
      if (v == 0) bus_bsy_i = 1; else bus_sel_i = 1;
      tick(1);
      bus_bsy_i = 0; bus_sel_i = 0;
      tick(FC - 1);
      chk("R3 count restarted", {31'd0, drv_bsy_o}, 0);
      tick(1);
      chk("R3 drive after full idle window", outs(), exp_outs(1, 1, 0, 8'h08));
      release_all();
    end

    // R7: SEL inside the arbitration delay
    own_id_i = 8'h80; arb_req_i = 1;
    tick(FC + 1);
    bus_data_i = 8'h80;
    tick(2);
    bus_sel_i = 1;
    tick(1);
    chk("R7 sel loss", outs(), exp_outs(0, 0, 1, 8'h00));
    bus_sel_i = 0;
    tick(FC + AD + 2);
    chk("R10 no retry on free bus", outs(), exp_outs(0, 0, 1, 8'h00));
    release_all();

    // R8: withdraw during wait and during competition
    own_id_i = 8'h02; arb_req_i = 1;
    tick(2);
    release_all();
    arb_req_i = 1;
    tick(FC + 3);
    chk("R4 competing", outs(), exp_outs(1, 1, 0, 8'h02));
    release_all();

    // R9: invalid IDs
    for (int k = 0; k < 3; k++) begin
      own_id_i = (k == 0) ? 8'h00 : ((k == 1) ? 8'h03 : 8'h81);
      arb_req_i = 1;
      tick(1);
      chk("R9 invalid id lost", outs(), exp_outs(0, 0, 1, 8'h00));
      tick(FC + AD + 2);
      chk("R9 never drives", outs(), exp_outs(0, 0, 1, 8'h00));
      release_all();
    end

    // R11: ID change after start
    own_id_i = 8'h10; arb_req_i = 1;
    tick(1);
    own_id_i = 8'h40;
    tick(FC);
    chk("R11 captured id driven", outs(), exp_outs(1, 1, 0, 8'h10));
    bus_data_i = 8'h50;
    tick(AD);
    chk("R11 compare uses captured id", outs(), exp_outs(0, 0, 1, 8'h00));
    release_all();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule